// File: doc/BRIEF.md
# Edge-Change GPIO Controller

This block is a register-mapped general-purpose I/O controller for up to 32 pins. It is reached over a plain 32-bit register port: a byte address, a write enable, write data, and combinational read data. Software sets each pin's direction, drives output levels, and reads pin levels. The writable part of the data register can be limited by a per-bit write mask.

Each pin's input goes through a two-stage synchroniser. Any transition on a synchronised input, rising or falling, sets a sticky per-pin change flag. Software acknowledges a flag by writing a one to it. A per-pin enable gates the flags into one combined interrupt line, which may be shared with other devices. The trigger mode cannot be configured: every pin reports both edges. A read-only register reports this mode.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, direction (0x00), data (0x04), enable (0x08) and change (0x0C) read 0. The write mask (0x10) reads all ones on implemented pins. `pin_oe_o`, `pin_o` and `irq_o` are 0.
- R2: Writing the direction register at 0x00 takes effect on `pin_oe_o` after the write edge. A bit of 1 is an output and 0 is an input.
- R3: Reading the data register at 0x04 returns the driven value for pins whose direction is 1. For input pins it returns the pin level, which appears on the second clock edge after a change at `pin_i`.
- R4: A write to 0x04 updates only those `pin_o` bits whose write-mask bit (0x10) is 1. The other bits keep their value.
- R5: A rising or a falling transition on `pin_i` sets that pin's bit in the change register at 0x0C. The bit is readable after the third clock edge following the transition.
- R6: Writing 1 to a change-register bit clears it. Writing 0 leaves the bit unchanged.
- R7: If an edge is registered in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R8: `irq_o` is high exactly while some pin has both its change bit and its enable bit (0x08) set. Change bits are recorded while the pin is disabled, so enabling a pin that is already flagged raises `irq_o` right after the write.
- R9: Register bits at or above N_PINS read 0 and ignore writes.
- R10: The trigger-type register at 0x14 reads all ones on implemented pins, meaning both edges, and ignores writes. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pin_i | input | N_PINS | Asynchronous pin levels |
| pin_o | output | N_PINS | Driven output levels |
| pin_oe_o | output | N_PINS | Output enable per pin |
| irq_o | output | 1 | Combined interrupt, level high |

## Verification
A corrupted change flag shows on `irq_o` in the cycle after the fault, provided the pin is enabled. For a disabled pin, the fault shows only on the next read of offset 0x0C. A lost edge, whether dropped by the synchroniser or by an acknowledge in the same cycle, is visible as a missing flag exactly three edges after the pin moved. The bench therefore reads the flags in the second and third cycles after each stimulus, so that both early and late detection are caught. Write-mask and direction faults appear on `pin_o` and `pin_oe_o` immediately after the write edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [2:0] {
    IDX_DIR  = 3'd0,
    IDX_DAT  = 3'd1,
    IDX_IEN  = 3'd2,
    IDX_CHG  = 3'd3,
    IDX_WMSK = 3'd4,
    IDX_TYPE = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  // both edges: any difference against last cycle
  assign edge_o = s2_q ^ prev_q;
endmodule

// File: rtl/gpio_chg_flags.sv
module gpio_chg_flags #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] chg_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (edge_i[i]) flag_q <= 1'b1;  // new event beats ack
      else if (clr_i[i])  flag_q <= 1'b0;
    end
    assign chg_o[i] = flag_q;
  end

  AST_SET_BY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((chg_o & ~$past(chg_o) & ~$past(edge_i)) == '0)); // R5
  AST_CLR_BY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~chg_o & $past(chg_o) & ~$past(clr_i)) == '0)); // R6
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(edge_i) & ~chg_o) == '0)); // R7
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N_PINS = 24,
  parameter int unsigned ADDR_W = 5   // must cover offset 0x14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  localparam int unsigned IW = ADDR_W - 2;
  localparam logic [N_PINS-1:0] ALL_ONES = '1;

  logic [IW-1:0]     word;
  logic [N_PINS-1:0] wd, dir_q, out_q, ien_q, msk_q;
  logic [N_PINS-1:0] lvl, edg, chg, clr, rd_pins;
  logic              wr_dir, wr_dat, wr_ien, wr_chg, wr_msk;

  assign word   = addr_i[ADDR_W-1:2];
  assign wd     = wdata_i[N_PINS-1:0];
  assign wr_dir = we_i && (word == IW'(IDX_DIR));
  assign wr_dat = we_i && (word == IW'(IDX_DAT));
  assign wr_ien = we_i && (word == IW'(IDX_IEN));
  assign wr_chg = we_i && (word == IW'(IDX_CHG));
  assign wr_msk = we_i && (word == IW'(IDX_WMSK));
  assign clr    = wr_chg ? wd : '0;

  logic unused_addr;
  assign unused_addr = ^addr_i[1:0];
  if (N_PINS < BUS_W) begin : g_pad
    logic unused_wd;
    assign unused_wd = ^wdata_i[BUS_W-1:N_PINS];
    assign rdata_o   = {{(BUS_W-N_PINS){1'b0}}, rd_pins};
  end else begin : g_full
    assign rdata_o = rd_pins;
  end

  gpio_in_sync #(.W(N_PINS)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .lvl_o(lvl), .edge_o(edg)
  );

  gpio_chg_flags #(.W(N_PINS)) u_flags (
    .clk_i (clk_i), .rst_ni(rst_ni), .edge_i(edg), .clr_i(clr), .chg_o(chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
      msk_q <= ALL_ONES;
    end else begin
      if (wr_dir) dir_q <= wd;
      if (wr_dat) out_q <= (out_q & ~msk_q) | (wd & msk_q);
      if (wr_ien) ien_q <= wd;
      if (wr_msk) msk_q <= wd;
    end
  end

  always_comb begin
    unique case (word)
      IW'(IDX_DIR):  rd_pins = dir_q;
      IW'(IDX_DAT):  rd_pins = (out_q & dir_q) | (lvl & ~dir_q);
      IW'(IDX_IEN):  rd_pins = ien_q;
      IW'(IDX_CHG):  rd_pins = chg;
      IW'(IDX_WMSK): rd_pins = msk_q;
      IW'(IDX_TYPE): rd_pins = ALL_ONES;
      default:       rd_pins = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(chg & ien_q);

  AST_OE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_oe_o) |-> $past(wr_dir)); // R2
  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_dat) |-> (((pin_o ^ $past(pin_o)) & ~$past(msk_q)) == '0)); // R4
  AST_OUT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_o) |-> $past(wr_dat)); // R4
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_q != '0)); // R8
  AST_IRQ_NEEDS_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (chg != '0)); // R8
endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
  localparam int unsigned N = 24;
  localparam logic [31:0] IMPL = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] pins = '0;
  logic [N-1:0] pout, poe;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  gpio_edge_ctrl #(.N_PINS(N), .ADDR_W(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  // monitor: compares queued read expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    #1;
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    pins = v;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk({31'b0, irq}, 32'h0, "R1 irq");
    chk({8'b0, poe}, 32'h0, "R1 oe");
    chk({8'b0, pout}, 32'h0, "R1 out");
    rd(5'h00, 32'h0, "R1 dir");
    rd(5'h04, 32'h0, "R1 data");
    rd(5'h08, 32'h0, "R1 ien");
    rd(5'h0C, 32'h0, "R1 chg");
    rd(5'h10, IMPL, "R1 wmask");
    // R2 direction
    wr(5'h00, 32'h0000_00F0);
    chk({8'b0, poe}, 32'h0000_00F0, "R2 oe");
    rd(5'h00, 32'h0000_00F0, "R2 dir rd");
    // R3 / R4 data writes and mask
    wr(5'h04, 32'h0000_005A);
    chk({8'b0, pout}, 32'h0000_005A, "R4 full mask");
    rd(5'h04, 32'h0000_0050, "R3 out readback");
    wr(5'h10, 32'h0000_000F);
    wr(5'h04, 32'h0000_00FF);
    chk({8'b0, pout}, 32'h0000_005F, "R4 partial mask");
    rd(5'h10, 32'h0000_000F, "R4 mask rd");
    // R9 upper bits
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, IMPL, "R9 upper dir");
    wr(5'h00, 32'h0000_00F0);
    // R10 type register and unmapped
    wr(5'h14, 32'h0);
    rd(5'h14, IMPL, "R10 type");
    rd(5'h18, 32'h0, "R10 unmapped");
    wr(5'h10, 32'hFFFF_FFFF);
    // R5 rising edge with timing, R3 input delay
    set_pins(24'h000001);
    rd(5'h04, 32'h0000_0050, "R3 before sync");
    rd(5'h04, 32'h0000_0051, "R3 after sync");
    rd(5'h0C, 32'h0000_0001, "R5 rise");
    chk({31'b0, irq}, 32'h0, "R8 disabled");
    // R8 enable after flag
    wr(5'h08, 32'h0000_0001);
    chk({31'b0, irq}, 32'h1, "R8 late enable");
    // R6 ack
    wr(5'h0C, 32'h0);
    rd(5'h0C, 32'h0000_0001, "R6 write zero");
    chk({31'b0, irq}, 32'h1, "R6 irq kept");
    wr(5'h0C, 32'h0000_0001);
    rd(5'h0C, 32'h0, "R6 write one");
    chk({31'b0, irq}, 32'h0, "R6 irq dropped");
    // R5 falling edge
    set_pins(24'h000000);
    rd(5'h0C, 32'h0, "R5 fall early1");
    rd(5'h0C, 32'h0, "R5 fall early2");
    rd(5'h0C, 32'h0000_0001, "R5 fall");
    chk({31'b0, irq}, 32'h1, "R8 fall irq");
    // R7 edge coinciding with ack
    set_pins(24'h000001);
    @(negedge clk);
    wr(5'h0C, 32'h0000_0001);
    rd(5'h0C, 32'h0000_0001, "R7 edge wins");
    wr(5'h0C, 32'h0000_0001);
    rd(5'h0C, 32'h0, "R7 later clear");
    // R8 masking
    set_pins(24'h000003);
    repeat (3) @(negedge clk);
    rd(5'h0C, 32'h0000_0002, "R5 pin1");
    chk({31'b0, irq}, 32'h0, "R8 masked");
    wr(5'h08, 32'h0000_0003);
    chk({31'b0, irq}, 32'h1, "R8 unmasked");
    // several pins at once
    set_pins(24'hA00303);
    repeat (3) @(negedge clk);
    rd(5'h0C, 32'h00A0_0302, "R5 multi");
    rd(5'h04, 32'h00A0_0353, "R3 mixed");
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, 32'h0, "R6 clear all");
    chk({31'b0, irq}, 32'h0, "R8 idle");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule